// File: doc/BRIEF.md
# I2C SCL Tap-Chain Timing Generator

This block sets the serial clock timing of an I2C master. A 6-bit divider code is split into two 3-bit selectors. One selector, taken from code bits 4..2, picks a first-tap delay and a tap spacing. The other, taken from code bits 5, 1 and 0, picks a tap count for the SCL phase and a tap count for the SDA hold. These taps are combined into a half-period length and an SDA hold length, both counted in system clocks. The block then drives a free-running SCL level.

The byte engine does not time anything itself. It uses three single-cycle strobes from this block: one on the last cycle of each SCL high phase, one on the last cycle of each SCL low phase, and one that marks when SDA may change after SCL has fallen. The divider code is a register input. A new code is picked up only at a whole-period boundary, or at any time while the generator is disabled. Deasserting the enable parks SCL high and clears all counting.

Top module: `scl_tap_timer`

## Requirements
- R1: Code bits [4:2] form a spacing index s (bit 4 is the MSB). The first tap F is 4, 4, 6, 6, 14, 30, 62 or 126 for s = 0..7, and the tap spacing is 2^s.
- R2: Code bits {5,1,0} form a tap index t (bit 5 is the MSB). The SCL tap count is 9, 10, 12, 15, 5, 6, 7 or 8 for t = 0..7. The SDA tap count is 3, 3, 4, 4, 1, 1, 2 or 2.
- R3: With H = F + (SCL taps − 1)·2^s + 2, the SCL period is 2·H system clocks. The high and low phases are each H clocks long. SCL starts high on the first enabled cycle. For example, code 0x00 gives 28, code 0x20 gives 20 and code 0x3F gives 2048.
- R4: scl_fall_o pulses for one cycle on the last cycle of every high phase. scl_rise_o pulses for one cycle on the last cycle of every low phase. At most one of the three strobes is high in any cycle.
- R5: With D = F + (SDA taps − 1)·2^s + 3, sda_upd_o pulses exactly once per low phase, D cycles after scl_fall_o. For example, code 0x00 gives 9, code 0x20 gives 7 and code 0x3F gives 257.
- R6: A change of div_code_i while enabled has no effect until the period in progress finishes, which is the cycle after scl_rise_o. From that cycle on, the new H and D apply.
- R7: While en_i is low, all strobes are low. One cycle after en_i goes low, scl_o is high. When en_i returns, the timing restarts with a full high phase, and the code in use is the one presented while disabled.
- R8: During reset, scl_o is high and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable; low holds the counters cleared |
| div_code_i | input | 6 | Divider code selecting the tap pairs |
| scl_o | output | 1 | SCL level, high when idle |
| scl_fall_o | output | 1 | Strobe on the last cycle of a high phase |
| scl_rise_o | output | 1 | Strobe on the last cycle of a low phase |
| sda_upd_o | output | 1 | Strobe marking when SDA may change |

## Verification
The bench checks every one of the 64 codes against cycle positions computed arithmetically. This catches wrong internal state at the ports within a single phase: a bad tap decode or a wrong half count moves the first scl_fall_o away from cycle H−1, and a bad hold count moves sda_upd_o away from H+D−1. A code latched at the wrong moment shows up as an edge one period early. A counter that is not cleared on disable shows up as a short first high phase after re-enable.

// File: rtl/scl_tap_pkg.sv
package scl_tap_pkg;

  localparam int CODE_W = 6;
  localparam int SEL_W  = 3;

  function automatic int first_tap(input logic [SEL_W-1:0] s);
    case (s)
      3'd0, 3'd1: first_tap = 4;
      3'd2, 3'd3: first_tap = 6;
      3'd4:       first_tap = 14;
      3'd5:       first_tap = 30;
      3'd6:       first_tap = 62;
      default:    first_tap = 126;
    endcase
  endfunction

  function automatic int scl_taps(input logic [SEL_W-1:0] t);
    case (t)
      3'd0:    scl_taps = 9;
      3'd1:    scl_taps = 10;
      3'd2:    scl_taps = 12;
      3'd3:    scl_taps = 15;
      3'd4:    scl_taps = 5;
      3'd5:    scl_taps = 6;
      3'd6:    scl_taps = 7;
      default: scl_taps = 8;
    endcase
  endfunction

  function automatic int sda_taps(input logic [SEL_W-1:0] t);
    case (t)
      3'd0, 3'd1: sda_taps = 3;
      3'd2, 3'd3: sda_taps = 4;
      3'd4, 3'd5: sda_taps = 1;
      default:    sda_taps = 2;
    endcase
  endfunction

endpackage

// File: rtl/scl_tap_decode.sv
module scl_tap_decode
  import scl_tap_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  half_o,
  output logic [CNT_W-1:0]  hold_o
);

  logic [SEL_W-1:0] spc_idx;
  logic [SEL_W-1:0] tap_idx;
  int               half_i;
  int               hold_i;

  assign spc_idx = code_i[4:2];
  assign tap_idx = {code_i[5], code_i[1:0]};

  // spacing is a power of two, so the product reduces to a shift
  always_comb begin
    half_i = first_tap(spc_idx) + ((scl_taps(tap_idx) - 1) << spc_idx) + 2;
    hold_i = first_tap(spc_idx) + ((sda_taps(tap_idx) - 1) << spc_idx) + 3;
  end

  assign half_o = CNT_W'(half_i);
  assign hold_o = CNT_W'(hold_i);

endmodule

// File: rtl/scl_tap_phase.sv
module scl_tap_phase #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             scl_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             scl_q, scl_d;
  logic             last;

  assign last = (cnt_q == half_i - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    scl_d = scl_q;
    if (!en_i) begin
      cnt_d = '0;
      scl_d = 1'b1;
    end else if (last) begin
      cnt_d = '0;
      scl_d = ~scl_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      scl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      scl_q <= scl_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign scl_o  = scl_q;
  assign last_o = last;

endmodule

// File: rtl/scl_tap_timer.sv
module scl_tap_timer
  import scl_tap_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              scl_o,
  output logic              scl_fall_o,
  output logic              scl_rise_o,
  output logic              sda_upd_o
);

  logic [CNT_W-1:0] dec_half, dec_hold;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] cnt;
  logic             scl_lvl;
  logic             phase_last;
  logic             load_en;

  scl_tap_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i (div_code_i),
    .half_o (dec_half),
    .hold_o (dec_hold)
  );

  scl_tap_phase #(.CNT_W(CNT_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .half_i (half_q),
    .cnt_o  (cnt),
    .scl_o  (scl_lvl),
    .last_o (phase_last)
  );

  // new counts are taken while idle or at the end of a low phase
  assign load_en = !en_i || (phase_last && !scl_lvl);

  always_comb begin
    half_d = half_q;
    hold_d = hold_q;
    if (load_en) begin
      half_d = dec_half;
      hold_d = dec_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= CNT_W'(28 / 2);
      hold_q <= CNT_W'(9);
    end else begin
      half_q <= half_d;
      hold_q <= hold_d;
    end
  end

  assign scl_o      = scl_lvl;
  assign scl_fall_o = en_i && scl_lvl && phase_last;
  assign scl_rise_o = en_i && !scl_lvl && phase_last;
  assign sda_upd_o  = en_i && !scl_lvl && (cnt == hold_q - CNT_W'(1));

endmodule

// File: rtl/scl_tap_checker.sv
module scl_tap_checker (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic scl_o,
  input logic scl_fall_o,
  input logic scl_rise_o,
  input logic sda_upd_o
);

  a_r4_fall_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> scl_o);

  a_r3_fall_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |=> !scl_o);

  a_r3_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |=> scl_o);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall_o, scl_rise_o, sda_upd_o}));

  a_r5_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_o |-> !scl_o);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !(scl_fall_o || scl_rise_o || sda_upd_o));

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> scl_o);

endmodule

bind scl_tap_timer scl_tap_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .scl_o      (scl_o),
  .scl_fall_o (scl_fall_o),
  .scl_rise_o (scl_rise_o),
  .sda_upd_o  (sda_upd_o)
);

// File: tb/sim_scl_tap_timer.sv
`timescale 1ns/1ps
module sim_scl_tap_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [5:0] div_code_i = '0;
  logic       scl_o, scl_fall_o, scl_rise_o, sda_upd_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  scl_tap_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .div_code_i (div_code_i),
    .scl_o      (scl_o),
    .scl_fall_o (scl_fall_o),
    .scl_rise_o (scl_rise_o),
    .sda_upd_o  (sda_upd_o)
  );

  function automatic int ft(input int s);
    int v[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    return v[s];
  endfunction
  function automatic int st(input int t);
    int v[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    return v[t];
  endfunction
  function automatic int dt(input int t);
    int v[8] = '{3, 3, 4, 4, 1, 1, 2, 2};
    return v[t];
  endfunction
  function automatic int half_of(input int c);
    int s = (c >> 2) & 7;
    int t = ((c >> 3) & 4) | (c & 3);
    return ft(s) + (st(t) - 1) * (1 << s) + 2;
  endfunction
  function automatic int hold_of(input int c);
    int s = (c >> 2) & 7;
    int t = ((c >> 3) & 4) | (c & 3);
    return ft(s) + (dt(t) - 1) * (1 << s) + 3;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare the outputs at position j of a period with counts h, d
  task automatic cmp_cycle(input int j, input int h, input int d, inout int bad);
    int p = j % (2 * h);
    if (scl_o      != (p < h))           bad++;
    if (scl_fall_o != (p == h - 1))      bad++;
    if (scl_rise_o != (p == 2 * h - 1))  bad++;
    if (sda_upd_o  != (p == h + d - 1))  bad++;
  endtask

  task automatic restart(input int code);
    @(negedge clk);
    en_i = 1'b0;
    div_code_i = 6'(code);
    @(negedge clk);
    @(negedge clk);
    en_i = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    int h, d, h2, d2;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", {31'd0, scl_o}, 1, "scl_o in reset");
    check("R8", {29'd0, scl_fall_o, scl_rise_o, sda_upd_o}, 0, "strobes in reset");
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R7: every code, two full periods from enable
    for (int c = 0; c < 64; c++) begin
      h = half_of(c);
      d = hold_of(c);
      restart(c);
      bad = 0;
      for (int k = 0; k < 4 * h; k++) begin
        #1;
        cmp_cycle(k, h, d, bad);
        @(negedge clk);
      end
      check("R1/R2/R3/R4/R5", bad, 0, $sformatf("mismatching cycles code %0d", c));
    end

    // R6: code change mid period takes effect after the rise strobe
    h = half_of(0);  d = hold_of(0);
    h2 = half_of(32); d2 = hold_of(32);
    check("R3", 2 * h2, 20, "period of code 0x20");
    check("R5", d2, 7, "hold of code 0x20");
    restart(0);
    bad = 0;
    for (int k = 0; k < 2 * h + 4 * h2; k++) begin
      #1;
      if (k == 5) div_code_i = 6'd32;
      if (k < 2 * h) cmp_cycle(k, h, d, bad);
      else           cmp_cycle(k - 2 * h, h2, d2, bad);
      @(negedge clk);
    end
    check("R6", bad, 0, "mismatches across code change");

    // R7: disable in the low phase, then re-enable with a full high phase
    restart(0);
    for (int k = 0; k < 20; k++) @(negedge clk);
    #1;
    check("R7", {31'd0, scl_o}, 0, "scl_o low before disable");
    en_i = 1'b0;
    #1;
    check("R7", {29'd0, scl_fall_o, scl_rise_o, sda_upd_o}, 0, "strobes while disabled");
    @(negedge clk);
    #1;
    check("R7", {31'd0, scl_o}, 1, "scl_o one cycle after disable");
    div_code_i = 6'd63;
    @(negedge clk);
    en_i = 1'b1;
    h = half_of(63); d = hold_of(63);
    check("R3", 2 * h, 2048, "period of code 0x3F");
    bad = 0;
    for (int k = 0; k < 2 * h; k++) begin
      #1;
      cmp_cycle(k, h, d, bad);
      @(negedge clk);
    end
    check("R7", bad, 0, "restart with code set while disabled");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule